// File: doc/BRIEF.md
# Periodic Read-Back versus Update Arbiter

This block arbitrates one downstream counter channel between two upstream request classes. The first class is a dense stream of counter-update requests, each carrying an address and an increment value. The second is a sparse stream of periodic read-back requests, each carrying only an address. A read-back request reads a counter out and clears it.

Read-back always wins. While a read-back is being granted, the update source sees its ready signal low and must hold its request. After every granted read-back, the read-back input is locked out for `HOLD_CLKS` clocks. During that lock-out, update traffic flows at the full rate of the channel. The winning request is placed in a single output register, tagged with a kind bit. The output register obeys downstream backpressure, so no request is lost or sent twice.

The asynchronous active-low reset is released through a two-stage synchronizer before it reaches the arbiter state.

Top module: `rbk_upd_arb`

## Requirements
- R1: When a read-back request is valid, the read-back lock-out is clear and the output slot is free, the read-back request is accepted on the next rising edge.
- R2: In any cycle where a read-back request is valid and its ready is high, the update ready is low.
- R3: After a read-back handshake, the read-back ready stays low for exactly `HOLD_CLKS` clocks. It rises again in the following clock if the output slot is free.
- R4: With the default parameters, the lock-out lasts 10 clocks.
- R5: While a read-back request is locked out, update requests are accepted whenever the output slot is free.
- R6: A request accepted at a rising edge is presented at the output right after that edge. `out_kind` is 1 for a read-back and 0 for an update. `out_addr` carries the request address. `out_data` carries the update value, or zero for a read-back.
- R7: While `out_valid` is high and `out_rdy` is low, both input readies are low and the output fields hold their values.
- R8: With `HOLD_CLKS` set to 0, read-back requests can be accepted on consecutive clocks.
- R9: During reset `out_valid` is low and both input readies are high.
- R10: When the output slot is free and no request is accepted, `out_valid` is low after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rbk_valid | input | 1 | Read-back request valid |
| rbk_ready | output | 1 | Read-back request accepted when high with valid |
| rbk_addr | input | ADDR_W | Read-back counter address |
| upd_valid | input | 1 | Update request valid |
| upd_ready | output | 1 | Update ready; low is the stall toward the generator |
| upd_addr | input | ADDR_W | Update counter address |
| upd_data | input | DATA_W | Update increment value |
| out_valid | output | 1 | Output request valid |
| out_ready | input | 1 | Downstream channel ready |
| out_kind | output | 1 | 1 = read-back, 0 = update |
| out_addr | output | ADDR_W | Output request address |
| out_data | output | DATA_W | Output update value, zero for read-back |

## Verification
The hardest situation to reach from the ports is a read-back arriving while it is still locked out, with downstream backpressure at the same time. Whether updates may proceed then depends on both the lock-out count and the occupancy of the output slot. The stimulus first runs a directed phase that keeps a read-back pending at all times with the channel open, which walks every lock-out cycle. It follows with a stall-only burst and then a long random phase with a weighted read-back rate and random `out_ready`. A second instance built with a zero lock-out is driven with back-to-back read-backs.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    KIND_UPD = 1'b0,
    KIND_RBK = 1'b1
  } req_kind_e;
endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/arb_holdoff.sv
module arb_holdoff #(
  parameter int HOLD_CLKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int HOLD_W = (HOLD_CLKS < 1) ? 1 : $clog2(HOLD_CLKS + 1);

  generate
    if (HOLD_CLKS == 0) begin : g_nohold
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst_n, load};
      assign busy = 1'b0;
    end else begin : g_hold
      logic [HOLD_W-1:0] cnt_q, cnt_d;
      logic              cnt_en;

      always_comb begin
        cnt_en = 1'b0;
        cnt_d  = cnt_q;
        if (load) begin
          cnt_en = 1'b1;
          cnt_d  = HOLD_W'(HOLD_CLKS);
        end else if (cnt_q != '0) begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign busy = (cnt_q != '0);
    end
  endgenerate
endmodule

// File: rtl/arb_select.sv
module arb_select #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 64
) (
  input  logic              slot_free,
  input  logic              hold_busy,
  input  logic              rbk_valid,
  input  logic [ADDR_W-1:0] rbk_addr,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [DATA_W-1:0] upd_data,
  output logic              rbk_ready,
  output logic              upd_ready,
  output logic              rbk_fire,
  output logic              pick_valid,
  output arb_pkg::req_kind_e pick_kind,
  output logic [ADDR_W-1:0] pick_addr,
  output logic [DATA_W-1:0] pick_data
);
  import arb_pkg::*;

  logic rbk_claim;

  always_comb begin
    rbk_claim = rbk_valid && !hold_busy;
    rbk_ready = slot_free && !hold_busy;
    upd_ready = slot_free && !rbk_claim;
    rbk_fire  = rbk_valid && rbk_ready;

    pick_valid = 1'b0;
    pick_kind  = KIND_UPD;
    pick_addr  = upd_addr;
    pick_data  = upd_data;
    if (rbk_fire) begin
      pick_valid = 1'b1;
      pick_kind  = KIND_RBK;
      pick_addr  = rbk_addr;
      pick_data  = '0;
    end else if (upd_valid && upd_ready) begin
      pick_valid = 1'b1;
    end
  end
endmodule

// File: rtl/arb_outreg.sv
module arb_outreg #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pick_valid,
  input  arb_pkg::req_kind_e pick_kind,
  input  logic [ADDR_W-1:0]  pick_addr,
  input  logic [DATA_W-1:0]  pick_data,
  output logic               slot_free,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_kind,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [DATA_W-1:0]  out_data
);
  import arb_pkg::*;

  logic              vld_q, vld_d;
  req_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              fld_en;

  always_comb begin
    slot_free = !vld_q || out_ready;
    vld_d     = slot_free ? pick_valid : vld_q;
    fld_en    = slot_free && pick_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= KIND_UPD;
      addr_q <= '0;
      data_q <= '0;
    end else if (fld_en) begin
      kind_q <= pick_kind;
      addr_q <= pick_addr;
      data_q <= pick_data;
    end
  end

  assign out_valid = vld_q;
  assign out_kind  = (kind_q == KIND_RBK);
  assign out_addr  = addr_q;
  assign out_data  = data_q;
endmodule

// File: rtl/rbk_upd_arb.sv
module rbk_upd_arb #(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 64,
  parameter int HOLD_CLKS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rbk_valid,
  output logic              rbk_ready,
  input  logic [ADDR_W-1:0] rbk_addr,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [DATA_W-1:0] upd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  import arb_pkg::*;

  logic              srst_n;
  logic              slot_free;
  logic              hold_busy;
  logic              rbk_fire;
  logic              pick_valid;
  req_kind_e         pick_kind;
  logic [ADDR_W-1:0] pick_addr;
  logic [DATA_W-1:0] pick_data;

  arb_rst_sync u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(srst_n)
  );

  arb_holdoff #(.HOLD_CLKS(HOLD_CLKS)) u_hold (
    .clk  (clk),
    .rst_n(srst_n),
    .load (rbk_fire),
    .busy (hold_busy)
  );

  arb_select #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sel (
    .slot_free (slot_free),
    .hold_busy (hold_busy),
    .rbk_valid (rbk_valid),
    .rbk_addr  (rbk_addr),
    .upd_valid (upd_valid),
    .upd_addr  (upd_addr),
    .upd_data  (upd_data),
    .rbk_ready (rbk_ready),
    .upd_ready (upd_ready),
    .rbk_fire  (rbk_fire),
    .pick_valid(pick_valid),
    .pick_kind (pick_kind),
    .pick_addr (pick_addr),
    .pick_data (pick_data)
  );

  arb_outreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (srst_n),
    .pick_valid(pick_valid),
    .pick_kind (pick_kind),
    .pick_addr (pick_addr),
    .pick_data (pick_data),
    .slot_free (slot_free),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_kind  (out_kind),
    .out_addr  (out_addr),
    .out_data  (out_data)
  );
endmodule

// File: rtl/rbk_upd_arb_chk.sv
module rbk_upd_arb_chk #(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 64,
  parameter int HOLD_CLKS = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rbk_valid,
  input logic              rbk_ready,
  input logic [ADDR_W-1:0] rbk_addr,
  input logic              upd_valid,
  input logic              upd_ready,
  input logic [ADDR_W-1:0] upd_addr,
  input logic [DATA_W-1:0] upd_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_kind,
  input logic [ADDR_W-1:0] out_addr,
  input logic [DATA_W-1:0] out_data
);
  a_r2_upd_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rbk_valid && rbk_ready) |-> !upd_ready);

  a_r7_inputs_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> (!rbk_ready && !upd_ready));

  a_r7_output_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) &&
                                   $stable(out_addr) && $stable(out_data)));

  a_r6_rbk_tagged: assert property (@(posedge clk) disable iff (!rst_n)
    (rbk_valid && rbk_ready) |=> (out_valid && out_kind &&
                                  out_addr == $past(rbk_addr) && out_data == '0));

  a_r6_upd_tagged: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready && !(rbk_valid && rbk_ready)) |=>
      (out_valid && !out_kind && out_addr == $past(upd_addr) &&
       out_data == $past(upd_data)));

  generate
    if (HOLD_CLKS > 0) begin : g_hold_chk
      a_r3_locked_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (rbk_valid && rbk_ready) |=> !rbk_ready);
    end
  endgenerate
endmodule

bind rbk_upd_arb rbk_upd_arb_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOLD_CLKS(HOLD_CLKS)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rbk_valid(rbk_valid), .rbk_ready(rbk_ready), .rbk_addr(rbk_addr),
  .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_addr(upd_addr),
  .upd_data(upd_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_kind(out_kind), .out_addr(out_addr), .out_data(out_data)
);

// File: tb/rbk_upd_arb_bench.sv
module rbk_upd_arb_bench;
  localparam int AW = 22;
  localparam int DW = 64;
  localparam int EXP_HOLD = 10;

  logic clk, rst_n;
  logic dv, dr, uv, ur, ov, ordy, ok;
  logic [AW-1:0] da, ua, oa;
  logic [DW-1:0] ud, od;
  logic zdv, zdr, zuv, zur, zov, zordy, zok;
  logic [AW-1:0] zda, zua, zoa;
  logic [DW-1:0] zud, zod;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  rbk_upd_arb u_rbk_upd_arb (
    .clk(clk), .rst_n(rst_n),
    .rbk_valid(dv), .rbk_ready(dr), .rbk_addr(da),
    .upd_valid(uv), .upd_ready(ur), .upd_addr(ua), .upd_data(ud),
    .out_valid(ov), .out_ready(ordy), .out_kind(ok), .out_addr(oa), .out_data(od)
  );

  rbk_upd_arb #(.HOLD_CLKS(0)) u_rbk_upd_arb_nohold (
    .clk(clk), .rst_n(rst_n),
    .rbk_valid(zdv), .rbk_ready(zdr), .rbk_addr(zda),
    .upd_valid(zuv), .upd_ready(zur), .upd_addr(zua), .upd_data(zud),
    .out_valid(zov), .out_ready(zordy), .out_kind(zok), .out_addr(zoa), .out_data(zod)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_rbk_ready(bit free, int since);
    return free && (since >= EXP_HOLD);
  endfunction

  function automatic bit exp_upd_ready(bit free, bit rv, int since);
    return free && !(rv && since >= EXP_HOLD);
  endfunction

  // model state
  bit            e_ov;
  bit            e_ok;
  logic [AW-1:0] e_oa;
  logic [DW-1:0] e_od;
  int            since;
  int            pd, pu, pr;
  bit            d_fired, u_fired;

  task automatic step();
    bit free, er, eu, df, uf;
    @(negedge clk);
    chk(e_ov ? "R6 out_valid" : "R10 out_valid", 64'(ov), 64'(e_ov));
    if (e_ov) begin
      chk("R6 out_kind", 64'(ok), 64'(e_ok));
      chk("R6 out_addr", 64'(oa), 64'(e_oa));
      chk("R6 out_data", od, e_od);
    end
    if (!dv || d_fired) begin
      dv = (($urandom % 100) < pd);
      da = AW'($urandom);
    end
    if (!uv || u_fired) begin
      uv = (($urandom % 100) < pu);
      ua = AW'($urandom);
      ud = {$urandom, $urandom};
    end
    ordy = (($urandom % 100) < pr);
    #1;
    free = !ov || ordy;
    er = exp_rbk_ready(free, since);
    eu = exp_upd_ready(free, dv, since);
    if (!free)                     chk("R7 rbk_ready", 64'(dr), 64'(er));
    else if (since == EXP_HOLD - 1) chk("R4 rbk_ready", 64'(dr), 64'(er));
    else if (since == EXP_HOLD)     chk("R4 rbk_ready", 64'(dr), 64'(er));
    else if (since < EXP_HOLD)      chk("R3 rbk_ready", 64'(dr), 64'(er));
    else                            chk("R1 rbk_ready", 64'(dr), 64'(er));
    if (!free)                       chk("R7 upd_ready", 64'(ur), 64'(eu));
    else if (dv && since >= EXP_HOLD) chk("R2 upd_ready", 64'(ur), 64'(eu));
    else if (dv)                      chk("R5 upd_ready", 64'(ur), 64'(eu));
    else                              chk("R5 upd_ready", 64'(ur), 64'(eu));
    df = dv && er;
    uf = uv && eu && !df;
    if (free) begin
      e_ov = df || uf;
      if (df) begin e_ok = 1'b1; e_oa = da; e_od = '0; end
      else if (uf) begin e_ok = 1'b0; e_oa = ua; e_od = ud; end
    end
    d_fired = df;
    u_fired = uf;
    if (df) since = 0;
    else if (since < 1000) since++;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    dv = 0; uv = 0; ordy = 0; da = '0; ua = '0; ud = '0;
    zdv = 0; zuv = 0; zordy = 1; zda = '0; zua = '0; zud = '0;
    repeat (3) @(negedge clk);
    chk("R9 out_valid", 64'(ov), 64'(0));
    chk("R9 rbk_ready", 64'(dr), 64'(1));
    chk("R9 upd_ready", 64'(ur), 64'(1));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    e_ov = 0; e_ok = 0; e_oa = '0; e_od = '0;
    since = 1000; d_fired = 0; u_fired = 0;
    // directed: read-back always pending, channel open
    pd = 100; pu = 100; pr = 100;
    for (int i = 0; i < 40; i++) step();
    // directed: downstream stall burst
    pr = 0;
    for (int i = 0; i < 6; i++) step();
    // random mix
    pd = 6; pu = 70; pr = 75;
    for (int i = 0; i < 4000; i++) step();
    pd = 0; pu = 0; pr = 100;
    for (int i = 0; i < 3; i++) step();
    // zero lock-out instance: back-to-back read-backs
    @(negedge clk);
    zdv = 1; zordy = 1; zda = 22'h1;
    for (int i = 0; i < 6; i++) begin
      #1;
      chk("R8 rbk_ready nohold", 64'(zdr), 64'(1));
      @(negedge clk);
      chk("R8 out_valid nohold", 64'(zov), 64'(1));
      chk("R8 out_kind nohold", 64'(zok), 64'(1));
      chk("R8 out_addr nohold", 64'(zoa), 64'(zda));
      zda = zda + 1'b1;
    end
    zdv = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule